// File: doc/BRIEF.md
# Banked RAM memory mapper

This block translates every 16-bit CPU address into a physical RAM location. The physical RAM is either the base 64K or one of up to eight extra 64K pages. The CPU space is split into four 16K windows. An 8-bit mapping register, loaded by CPU I/O writes, decides for each window whether it goes to the base RAM or to an extra page, and which 16K bank within that 64K it reaches. The outputs give a base/extended select, the page number, the bank number and the 14-bit offset inside the bank. The RAM device uses these outputs directly.

The register holds a page field, a single-slot flag and a 2-bit select field. The translator first decodes the register into one of five named mapping modes:

- `MAP_BASE_ONLY`: flag 0, select 00.
- `MAP_TOP_EXT`: flag 0, select 01.
- `MAP_ALL_EXT`: flag 0, select 10.
- `MAP_SWAP_TOP`: flag 0, select 11.
- `MAP_WIN1_PICK`: flag 1, any select.

The register has two states. Reset puts it in the cleared state, which is `MAP_BASE_ONLY`. From there the only transition is a write that the port accepts, and that write loads the data byte. Any other cycle holds the current value. The video fetch path never passes through this block, so the register cannot affect it.

Top module: `ram_bank_mapper`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted write, the register is zero. Every window then reads base RAM, with `bank_num` equal to the window index and `page_num` equal to 0.
- R2: The register loads `io_data` at a rising clock edge when all of these hold: `io_wr` is 1, `cpu_addr[15]` is 0, `cpu_addr[14]` is 1, and `io_data[7:6]` is 11. The fields are: page = `io_data[5:3]`, flag = `io_data[2]`, select = `io_data[1:0]`.
- R3: A write with `cpu_addr[14]`=0, or with `cpu_addr[15]`=1, or a cycle with `io_wr`=0, leaves the mapping unchanged.
- R4: An accepted-port write whose `io_data[7:6]` is not 11 leaves the mapping unchanged.
- R5: With flag 0 and select 00, windows 0 to 3 map to base banks 0 to 3.
- R6: With flag 0 and select 01, windows 0 to 2 map to base banks 0 to 2, and window 3 maps to page p, bank 3.
- R7: With flag 0 and select 10, windows 0 to 3 map to page p, banks 0 to 3.
- R8: With flag 0 and select 11, the windows map to base bank 0, base bank 3, base bank 2, and page p bank 3, in that order.
- R9: With flag 1, window 1 maps to page p, bank b, where b is the select field. Windows 0, 2 and 3 map to base banks 0, 2 and 3.
- R10: `ext_sel` is 1 only for windows mapped to page p. `page_num` reads 0 whenever `ext_sel` is 0.
- R11: `bank_offset` equals `cpu_addr[13:0]` in every mode.
- R12: The translation is combinational. A new address is reflected in the same cycle, and a loaded value applies right after the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address (memory or I/O) |
| io_wr | input | 1 | CPU I/O write strobe, active high |
| io_data | input | 8 | CPU I/O write data |
| ext_sel | output | 1 | 1 = extended page, 0 = base 64K |
| page_num | output | 3 | Extended page number, 0 for base |
| bank_num | output | 2 | 16K bank within the selected 64K |
| bank_offset | output | 14 | Offset inside the bank |

## Verification
A write becomes visible one edge after the strobe: the register captures on the rising edge, and the translation follows it combinationally. The bench therefore drives a write on a falling edge and drops the strobe at the next falling edge. It then applies the CPU address and samples the outputs one nanosecond later, well before the next rising edge. Address-only changes need no clock, so they are sampled the same way within the same half period. Reset clears the register asynchronously, so the reset check is taken while `rst_n` is still low.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int PAGE_W = 3;
    localparam int SEL_W  = 2;
    localparam int TAG_W  = 2;
    localparam logic [TAG_W-1:0] LOAD_TAG = 2'b11;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [PAGE_W-1:0] page;
        logic              slot;
        logic [SEL_W-1:0]  sel;
    } map_cfg_t;

    typedef enum logic [2:0] {
        MAP_BASE_ONLY,
        MAP_TOP_EXT,
        MAP_ALL_EXT,
        MAP_SWAP_TOP,
        MAP_WIN1_PICK
    } map_mode_e;

endpackage

// File: rtl/mapper_port_decode.sv
module mapper_port_decode (
    input  logic       io_wr,
    input  logic [1:0] addr_hi,
    output logic       port_hit
);
    // Port is selected by address bit 15 low and bit 14 high.
    always_comb begin
        port_hit = io_wr && (addr_hi == 2'b01);
    end
endmodule

// File: rtl/mapper_cfg_reg.sv
module mapper_cfg_reg
    import mapper_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     port_hit,
    input  map_cfg_t wr_data,
    output map_cfg_t cfg_q
);
    logic load_en;

    always_comb begin
        load_en = port_hit && (wr_data.tag == LOAD_TAG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load_en) begin
            cfg_q <= wr_data;
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit && wr_data.tag == LOAD_TAG) |=> (cfg_q == $past(wr_data)));

    assert_no_port_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !port_hit |=> $stable(cfg_q));

    assert_bad_tag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit && wr_data.tag != LOAD_TAG) |=> $stable(cfg_q));
endmodule

// File: rtl/mapper_window_xlate.sv
module mapper_window_xlate
    import mapper_pkg::*;
#(
    parameter int WIN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_W-1:0]  window,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic              cfg_slot,
    input  logic [SEL_W-1:0]  cfg_sel,
    output logic              ext_sel,
    output logic [PAGE_W-1:0] page_num,
    output logic [WIN_W-1:0]  bank_num
);
    localparam logic [WIN_W-1:0] WIN_LOW  = WIN_W'(1);
    localparam logic [WIN_W-1:0] WIN_TOP  = WIN_W'(3);

    map_mode_e mode;

    // Mode decode from the register.
    always_comb begin
        if (cfg_slot) begin
            mode = MAP_WIN1_PICK;
        end else begin
            unique case (cfg_sel)
                2'b00:   mode = MAP_BASE_ONLY;
                2'b01:   mode = MAP_TOP_EXT;
                2'b10:   mode = MAP_ALL_EXT;
                default: mode = MAP_SWAP_TOP;
            endcase
        end
    end

    // Per-window output decode.
    logic use_ext;
    always_comb begin
        use_ext  = 1'b0;
        bank_num = window;
        unique case (mode)
            MAP_BASE_ONLY: ;
            MAP_TOP_EXT:   use_ext = (window == WIN_TOP);
            MAP_ALL_EXT:   use_ext = 1'b1;
            MAP_SWAP_TOP: begin
                if (window == WIN_LOW) begin
                    bank_num = WIN_TOP;
                end else if (window == WIN_TOP) begin
                    use_ext = 1'b1;
                end
            end
            MAP_WIN1_PICK: begin
                if (window == WIN_LOW) begin
                    use_ext  = 1'b1;
                    bank_num = WIN_W'(cfg_sel);
                end
            end
            default: ;
        endcase
        ext_sel  = use_ext;
        page_num = use_ext ? cfg_page : '0;
    end

    assert_identity_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_slot && cfg_sel == 2'b00) |-> (!ext_sel && bank_num == window));

    assert_all_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_slot && cfg_sel == 2'b10) |-> (ext_sel && bank_num == window && page_num == cfg_page));

    assert_swap_win1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_slot && cfg_sel == 2'b11 && window == WIN_LOW) |-> (!ext_sel && bank_num == WIN_TOP));

    assert_pick_only_win1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_slot |-> (ext_sel == (window == WIN_LOW)));
endmodule

// File: rtl/ram_bank_mapper.sv
module ram_bank_mapper
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                io_wr,
    input  logic [7:0]          io_data,
    output logic                ext_sel,
    output logic [PAGE_W-1:0]   page_num,
    output logic [1:0]          bank_num,
    output logic [ADDR_W-3:0]   bank_offset
);
    localparam int WIN_W = 2;
    localparam int OFF_W = ADDR_W - WIN_W;

    logic     port_hit;
    map_cfg_t cfg_q;

    mapper_port_decode u_decode (
        .io_wr    (io_wr),
        .addr_hi  (cpu_addr[ADDR_W-1 -: WIN_W]),
        .port_hit (port_hit)
    );

    mapper_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_hit (port_hit),
        .wr_data  (map_cfg_t'(io_data)),
        .cfg_q    (cfg_q)
    );

    mapper_window_xlate #(.WIN_W(WIN_W)) u_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .window   (cpu_addr[ADDR_W-1 -: WIN_W]),
        .cfg_page (cfg_q.page),
        .cfg_slot (cfg_q.slot),
        .cfg_sel  (cfg_q.sel),
        .ext_sel  (ext_sel),
        .page_num (page_num),
        .bank_num (bank_num)
    );

    assign bank_offset = cpu_addr[OFF_W-1:0];

    assert_base_page_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_sel |-> (page_num == '0));
endmodule

// File: tb/sim_ram_bank_mapper.sv
module sim_ram_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic [7:0]  io_data = 8'h00;
    logic        ext_sel;
    logic [2:0]  page_num;
    logic [1:0]  bank_num;
    logic [13:0] bank_offset;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ram_bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_wr(io_wr),
        .io_data(io_data), .ext_sel(ext_sel), .page_num(page_num),
        .bank_num(bank_num), .bank_offset(bank_offset)
    );

    // {data[15:8], window[7:6], ext[5], page[4:2], bank[1:0]}
    localparam logic [15:0] VEC [24] = '{
        {8'hC0,2'd0,1'b0,3'd0,2'd0}, {8'hC0,2'd1,1'b0,3'd0,2'd1},
        {8'hC0,2'd2,1'b0,3'd0,2'd2}, {8'hC0,2'd3,1'b0,3'd0,2'd3},
        {8'hE9,2'd0,1'b0,3'd0,2'd0}, {8'hE9,2'd1,1'b0,3'd0,2'd1},
        {8'hE9,2'd2,1'b0,3'd0,2'd2}, {8'hE9,2'd3,1'b1,3'd5,2'd3},
        {8'hDA,2'd0,1'b1,3'd3,2'd0}, {8'hDA,2'd1,1'b1,3'd3,2'd1},
        {8'hDA,2'd2,1'b1,3'd3,2'd2}, {8'hDA,2'd3,1'b1,3'd3,2'd3},
        {8'hF3,2'd0,1'b0,3'd0,2'd0}, {8'hF3,2'd1,1'b0,3'd0,2'd3},
        {8'hF3,2'd2,1'b0,3'd0,2'd2}, {8'hF3,2'd3,1'b1,3'd6,2'd3},
        {8'hFD,2'd0,1'b0,3'd0,2'd0}, {8'hFD,2'd1,1'b1,3'd7,2'd1},
        {8'hFD,2'd2,1'b0,3'd0,2'd2}, {8'hFD,2'd3,1'b0,3'd0,2'd3},
        {8'hD6,2'd0,1'b0,3'd0,2'd0}, {8'hD6,2'd1,1'b1,3'd2,2'd2},
        {8'hD6,2'd2,1'b0,3'd0,2'd2}, {8'hD6,2'd3,1'b0,3'd0,2'd3}
    };

    task automatic check(input string req, input logic e_ext, input logic [2:0] e_page,
                         input logic [1:0] e_bank, input logic [13:0] e_off);
        checks++;
        if (ext_sel !== e_ext || page_num !== e_page || bank_num !== e_bank || bank_offset !== e_off) begin
            failures++;
            $display("FAIL %s addr=%h act ext=%b page=%0d bank=%0d off=%h exp ext=%b page=%0d bank=%0d off=%h",
                     req, cpu_addr, ext_sel, page_num, bank_num, bank_offset,
                     e_ext, e_page, e_bank, e_off);
        end
    endtask

    task automatic io_write(input logic [15:0] port, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        cpu_addr = port;
        io_data  = d;
        io_wr    = strobe;
        @(negedge clk);
        io_wr    = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, checked while reset is held
        repeat (3) @(negedge clk);
        for (int w = 0; w < 4; w++) begin
            probe({w[1:0], 14'h0101});
            check("R1 reset", 1'b0, 3'd0, w[1:0], 14'h0101);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R5-R9, R10, R11, R12: vector table
        for (int i = 0; i < 24; i++) begin
            logic [7:0]  d;
            logic [13:0] off;
            string       req;
            d   = VEC[i][15:8];
            off = 14'((i * 16'h0123) ^ 16'h2A5C);
            if (d[2]) req = "R9";
            else case (d[1:0])
                2'd0: req = "R5";
                2'd1: req = "R6";
                2'd2: req = "R7";
                default: req = "R8";
            endcase
            io_write(16'h7F00, d, 1'b1); // R2 load
            probe({VEC[i][7:6], off});
            check({req, " R10 R11 R12"}, VEC[i][5], VEC[i][4:2], VEC[i][1:0], off);
        end

        // R12: address change alone, no clock edge
        io_write(16'h7F00, 8'hDA, 1'b1);
        probe(16'h8000);
        check("R12 addr only", 1'b1, 3'd3, 2'd2, 14'h0000);
        probe(16'hFFFF);
        check("R12 addr only", 1'b1, 3'd3, 2'd3, 14'h3FFF);

        // R3: rejected by address bit 14 low
        io_write(16'h3F00, 8'hC0, 1'b1);
        probe(16'h0010);
        check("R3 bit14 low", 1'b1, 3'd3, 2'd0, 14'h0010);
        // R3: rejected by address bit 15 high
        io_write(16'hFF00, 8'hC0, 1'b1);
        probe(16'h0020);
        check("R3 bit15 high", 1'b1, 3'd3, 2'd0, 14'h0020);
        // R3: strobe low
        io_write(16'h7F00, 8'hC0, 1'b0);
        probe(16'h0030);
        check("R3 no strobe", 1'b1, 3'd3, 2'd0, 14'h0030);

        // R4: tag not 11
        io_write(16'h7F00, 8'h40, 1'b1);
        probe(16'h4000);
        check("R4 tag 01", 1'b1, 3'd3, 2'd1, 14'h0000);
        io_write(16'h7F00, 8'h80, 1'b1);
        probe(16'h4000);
        check("R4 tag 10", 1'b1, 3'd3, 2'd1, 14'h0000);
        io_write(16'h7F00, 8'h00, 1'b1);
        probe(16'h4000);
        check("R4 tag 00", 1'b1, 3'd3, 2'd1, 14'h0000);

        // R2: port bit 14 with other low bits, flag and page fields
        io_write(16'h40FF, 8'hCE, 1'b1); // page 1, flag 1, sel 2
        probe(16'h5555);
        check("R2 load fields", 1'b1, 3'd1, 2'd2, 14'h1555);
        probe(16'hC000);
        check("R2 R10 base win3", 1'b0, 3'd0, 2'd3, 14'h0000);

        // R1: reset during operation clears the mapping
        @(negedge clk);
        rst_n = 1'b0;
        probe(16'h4321);
        check("R1 mid reset", 1'b0, 3'd0, 2'd1, 14'h0321);
        @(negedge clk);
        rst_n = 1'b1;
        probe(16'hC123);
        check("R1 after reset", 1'b0, 3'd0, 2'd3, 14'h0123);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule